// File: doc/BRIEF.md
# Page Write Collector and Commit Sequencer

This block sits behind a serial memory client and handles the write side of a transaction. After the client has decoded a write header, it loads the starting address. Each received data byte is placed into a one-page buffer at the offset given by the low address bits. Only those low bits advance after each byte, and they wrap inside the page. A per-offset valid mask records which buffer slots hold new data.

On the closing STOP the block samples the write-protect level and decides whether to run a self-timed write cycle. It runs one only when at least one byte arrived and protection is off. The cycle lasts a fixed, parameterised number of clocks, and `busy_o` is high for all of it. In the first page-size clocks of the cycle the buffer is scanned. A memory write is issued only for the offsets that hold new data, so the other bytes of the page keep their old contents. While busy, every bus-side input is ignored. A protected or empty STOP discards the buffer, and the block is ready again in the next cycle.

Top module: `page_write_seq`

## Requirements
- R1: After reset `busy_o` is 0, `mem_we_o` is 0 and `addr_o` is 0.
- R2: A `start_i` pulse while idle loads `start_addr_i` into `addr_o`. Each accepted byte then increments only the low PAGE_W bits of `addr_o`. From all ones these bits wrap to 0, and the upper bits never change.
- R3: A `stop_i` pulse with `wp_i` low, after at least one byte, raises `busy_o` in the next cycle. `busy_o` then stays high for exactly CYCLE_CLKS cycles.
- R4: During that cycle, each buffered offset is written once to memory address {page, offset} with its byte. Offsets not written in the transaction receive no memory write.
- R5: When wrap makes an offset receive two bytes, the later byte is the one written to memory.
- R6: A `stop_i` with no byte since the last `start_i` does not raise `busy_o` and issues no memory write.
- R7: A `stop_i` with `wp_i` high does not raise `busy_o` and writes nothing. The buffered bytes are dropped, and the next transaction is accepted in the following cycle.
- R8: Changing `wp_i` while `busy_o` is high does not shorten, stop or alter the running write cycle.
- R9: While `busy_o` is high, `start_i`, `byte_valid_i` and `stop_i` are ignored. `addr_o` holds, and no byte offered then is ever committed.
- R10: A `start_i` discards any bytes buffered but not yet committed. A later STOP commits only the bytes received after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Write header accepted; load start address and empty buffer |
| start_addr_i | input | ADDR_W | Starting byte address of the transaction |
| byte_valid_i | input | 1 | One received data byte is present |
| byte_data_i | input | DATA_W | The received data byte |
| stop_i | input | 1 | STOP condition seen on the bus |
| wp_i | input | 1 | Write-protect level, sampled at STOP |
| busy_o | output | 1 | Self-timed write cycle in progress |
| mem_we_o | output | 1 | Backing memory write strobe |
| mem_addr_o | output | ADDR_W | Backing memory write address |
| mem_data_o | output | DATA_W | Backing memory write data |
| addr_o | output | ADDR_W | Current shared address counter |

## Verification
A wrong buffer offset or mask shows up at the end of the write cycle: the bench's memory image then differs from the arithmetic model, either in the slot that was hit or in one left untouched. A broken address counter shows on `addr_o` one cycle after the byte that misstepped it, and a faulty cycle length or protection decision shows in the busy count measured just after STOP. Inputs offered during busy are checked through `addr_o` at once and through the memory image after a following empty STOP.

// File: rtl/pws_pkg.sv
package pws_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_HOLD = 2'd2
    } pws_state_e;

endpackage

// File: rtl/pws_page_buffer.sv
module pws_page_buffer #(
    parameter int PAGE_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              we_i,
    input  logic [PAGE_W-1:0] wr_off_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [PAGE_W-1:0] rd_idx_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              any_valid_o
);
    localparam int PAGE_BYTES = 1 << PAGE_W;

    typedef struct packed {
        logic [PAGE_BYTES-1:0]             mask;
        logic [PAGE_BYTES-1:0][DATA_W-1:0] data;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (clear_i) begin
            buf_d.mask = '0;
        end else if (we_i) begin
            // later byte at the same offset simply replaces the earlier one
            buf_d.mask[wr_off_i] = 1'b1;
            buf_d.data[wr_off_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign rd_valid_o  = buf_q.mask[rd_idx_i];
    assign rd_data_o   = buf_q.data[rd_idx_i];
    assign any_valid_o = |buf_q.mask;

    // R10: a discard leaves nothing pending
    p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !any_valid_o);

endmodule

// File: rtl/pws_commit_ctrl.sv
module pws_commit_ctrl
    import pws_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int PAGE_W     = 8,
    parameter int CYCLE_CLKS = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              byte_valid_i,
    input  logic              stop_i,
    input  logic              wp_i,
    input  logic              any_valid_i,
    output logic              busy_o,
    output logic              scan_o,
    output logic [PAGE_W-1:0] idx_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              clear_o,
    output logic              accept_o
);
    localparam int CNT_W = $clog2(CYCLE_CLKS + 1);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(CYCLE_CLKS - 1);
    localparam logic [PAGE_W-1:0] IDX_LAST = '1;

    typedef struct packed {
        pws_state_e        state;
        logic [PAGE_W-1:0] idx;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic clear_d, accept_d;

    always_comb begin
        ctl_d    = ctl_q;
        clear_d  = 1'b0;
        accept_d = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.addr = start_addr_i;
                    clear_d    = 1'b1;
                end else if (byte_valid_i) begin
                    accept_d = 1'b1;
                    ctl_d.addr[PAGE_W-1:0] = ctl_q.addr[PAGE_W-1:0] + PAGE_W'(1);
                end else if (stop_i) begin
                    if (any_valid_i && !wp_i) begin
                        ctl_d.state = ST_SCAN;
                        ctl_d.idx   = '0;
                        ctl_d.cnt   = '0;
                    end else begin
                        clear_d = 1'b1;
                    end
                end
            end
            ST_SCAN, ST_HOLD: begin
                ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                if (ctl_q.state == ST_SCAN) begin
                    if (ctl_q.idx == IDX_LAST) begin
                        ctl_d.state = ST_HOLD;
                    end else begin
                        ctl_d.idx = ctl_q.idx + PAGE_W'(1);
                    end
                end
                if (ctl_q.cnt == CNT_LAST) begin
                    ctl_d.state = ST_IDLE;
                    clear_d     = 1'b1;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, idx: '0, cnt: '0, addr: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o   = (ctl_q.state != ST_IDLE);
    assign scan_o   = (ctl_q.state == ST_SCAN);
    assign idx_o    = ctl_q.idx;
    assign addr_o   = ctl_q.addr;
    assign clear_o  = clear_d;
    assign accept_o = accept_d;

    // R2: an accepted byte never moves the page bits
    p_upper_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && byte_valid_i && !start_i)
        |=> (addr_o[ADDR_W-1:PAGE_W] == $past(addr_o[ADDR_W-1:PAGE_W])));

    // R6: stop with an empty buffer starts no cycle
    p_empty_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && stop_i && !start_i && !byte_valid_i && !any_valid_i) |=> !busy_o);

endmodule

// File: rtl/page_write_seq.sv
module page_write_seq #(
    parameter int ADDR_W     = 18,
    parameter int PAGE_W     = 8,
    parameter int DATA_W     = 8,
    parameter int CYCLE_CLKS = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              byte_valid_i,
    input  logic [DATA_W-1:0] byte_data_i,
    input  logic              stop_i,
    input  logic              wp_i,
    output logic              busy_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_data_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic              scan;
    logic [PAGE_W-1:0] idx;
    logic              clear;
    logic              accept;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              any_valid;

    pws_commit_ctrl #(
        .ADDR_W    (ADDR_W),
        .PAGE_W    (PAGE_W),
        .CYCLE_CLKS(CYCLE_CLKS)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_addr_i(start_addr_i),
        .byte_valid_i(byte_valid_i),
        .stop_i      (stop_i),
        .wp_i        (wp_i),
        .any_valid_i (any_valid),
        .busy_o      (busy_o),
        .scan_o      (scan),
        .idx_o       (idx),
        .addr_o      (addr_o),
        .clear_o     (clear),
        .accept_o    (accept)
    );

    pws_page_buffer #(
        .PAGE_W(PAGE_W),
        .DATA_W(DATA_W)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear),
        .we_i       (accept),
        .wr_off_i   (addr_o[PAGE_W-1:0]),
        .wr_data_i  (byte_data_i),
        .rd_idx_i   (idx),
        .rd_valid_o (rd_valid),
        .rd_data_o  (rd_data),
        .any_valid_o(any_valid)
    );

    assign mem_we_o   = scan && rd_valid;
    assign mem_addr_o = {addr_o[ADDR_W-1:PAGE_W], idx};
    assign mem_data_o = rd_data;

    // R9: the address counter is frozen while the cycle runs
    p_hold_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(addr_o));

    // R7: a protected stop from idle never enters the cycle
    p_wp_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && stop_i && wp_i) |=> !busy_o);

    // R4: a finished cycle leaves no stale bytes pending
    p_drained_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !any_valid);

endmodule

// File: tb/page_write_seq_test.sv
module page_write_seq_test;
    localparam int AW = 6;
    localparam int PW = 3;
    localparam int DW = 8;
    localparam int CYC = 20;
    localparam int PB = 1 << PW;
    localparam int MEMSZ = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic byte_valid_i = 1'b0;
    logic [DW-1:0] byte_data_i = '0;
    logic stop_i = 1'b0;
    logic wp_i = 1'b0;
    logic busy_o, mem_we_o;
    logic [AW-1:0] mem_addr_o, addr_o;
    logic [DW-1:0] mem_data_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int seed = 1;

    logic [DW-1:0] sim_mem [MEMSZ];
    logic [DW-1:0] exp_mem [MEMSZ];

    always #5 clk = ~clk;

    page_write_seq #(.ADDR_W(AW), .PAGE_W(PW), .DATA_W(DW), .CYCLE_CLKS(CYC)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i), .stop_i(stop_i),
        .wp_i(wp_i), .busy_o(busy_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_data_o(mem_data_o), .addr_o(addr_o)
    );

    always @(negedge clk) begin
        if (rst_n && mem_we_o) sim_mem[mem_addr_o] <= mem_data_o;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_start(input int a);
        @(negedge clk);
        start_i = 1'b1; start_addr_i = AW'(a);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic do_byte(input int d);
        byte_valid_i = 1'b1; byte_data_i = DW'(d);
        @(negedge clk);
        byte_valid_i = 1'b0;
    endtask

    // pulse stop; return number of busy cycles. flip toggles wp and offers junk during busy
    task automatic do_stop(input bit wp, input bit flip, output int n);
        stop_i = 1'b1; wp_i = wp;
        @(negedge clk);
        stop_i = 1'b0;
        n = 0;
        while (busy_o && n < CYC + 10) begin
            n++;
            if (flip) begin
                wp_i = ~wp_i;
                start_i = n[0];
                start_addr_i = AW'(n * 7);
                byte_valid_i = ~n[0];
                byte_data_i = 8'hEE;
                stop_i = (n == 3);
            end
            @(negedge clk);
        end
        start_i = 1'b0; byte_valid_i = 1'b0; stop_i = 1'b0; wp_i = 1'b0;
    endtask

    task automatic mem_compare(input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < MEMSZ; i++) begin
            if (sim_mem[i] !== exp_mem[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        check(bad == 0, req, (first < 0) ? 0 : int'(sim_mem[first]),
              (first < 0) ? 0 : int'(exp_mem[first]));
    endtask

    task automatic run_txn(input int page, input int off, input int nb, input bit wp);
        int n;
        do_start(page * PB + off);
        for (int i = 0; i < nb; i++) begin
            seed = (seed * 37 + 11) % 251;
            if (!wp) exp_mem[page * PB + ((off + i) % PB)] = DW'(seed);
            do_byte(seed);
        end
        check(addr_o == AW'(page * PB + ((off + nb) % PB)), "R2 address after bytes",
              int'(addr_o), page * PB + ((off + nb) % PB));
        do_stop(wp, 1'b0, n);
        if (wp) check(n == 0, "R7 protected stop busy", n, 0);
        else if (nb == 0) check(n == 0, "R6 empty stop busy", n, 0);
        else check(n == CYC, "R3 busy length", n, CYC);
        if (nb > PB - off) mem_compare("R5 wrap overwrite memory");
        else mem_compare("R4 memory image");
    endtask

    initial begin
        int n;
        int saved;
        for (int i = 0; i < MEMSZ; i++) begin
            sim_mem[i] = '0;
            exp_mem[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o == 1'b0, "R1 busy after reset", int'(busy_o), 0);
        check(mem_we_o == 1'b0, "R1 we after reset", int'(mem_we_o), 0);
        check(addr_o == '0, "R1 addr after reset", int'(addr_o), 0);

        // sweep over protection, offset and length
        for (int wp = 0; wp < 2; wp++) begin
            for (int off = 0; off < PB; off++) begin
                for (int k = 0; k < 5; k++) begin
                    int lens [5] = '{0, 1, 3, 8, 11};
                    run_txn((off + k + wp) % PB, off, lens[k], bit'(wp));
                end
            end
        end

        // R8 and R9: wp toggling and junk inputs during the cycle
        do_start(5 * PB + 6);
        seed = 91; exp_mem[5 * PB + 6] = DW'(seed); do_byte(seed);
        seed = 92; exp_mem[5 * PB + 7] = DW'(seed); do_byte(seed);
        saved = int'(addr_o);
        do_stop(1'b0, 1'b1, n);
        check(n == CYC, "R8 busy length with wp toggling", n, CYC);
        check(addr_o == AW'(saved), "R9 addr held through busy", int'(addr_o), saved);
        mem_compare("R8 commit despite wp change");
        do_stop(1'b0, 1'b0, n);
        check(n == 0, "R9 junk bytes not buffered", n, 0);
        mem_compare("R9 no junk committed");

        // R10: restart discards pending bytes
        do_start(2 * PB + 1);
        seed = 201; do_byte(seed);
        seed = 202; do_byte(seed);
        do_start(4 * PB + 3);
        seed = 203; exp_mem[4 * PB + 3] = DW'(seed); do_byte(seed);
        do_stop(1'b0, 1'b0, n);
        check(n == CYC, "R10 busy after restart", n, CYC);
        mem_compare("R10 only later bytes committed");
        do_start(1 * PB + 0);
        do_stop(1'b0, 1'b0, n);
        check(n == 0, "R10 restart alone leaves nothing", n, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule